// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Loader

This block is the write path of a byte-wide memory that behaves like a static RAM on its pins. Writes arrive on active-low chip-enable, write-enable and output-enable strobes. These strobes are sampled synchronously on `clk`. Accepted bytes go into a page buffer. Each buffered byte has its own "loaded" bit, and one buffer holds a whole page of `2**PAGE_W` bytes. The upper address bits select the page and the low `PAGE_W` bits select the byte within it.

The first accepted byte opens a load period and fixes the page. Later bytes are accepted in any order while the gap between them stays shorter than `BYTE_WINDOW` cycles. When the gap runs out, the block raises `busy` and starts a program phase that lasts `PROG_CYCLES` cycles. During its first `2**PAGE_W` cycles the program phase walks the buffer and writes only the loaded bytes into a behavioural storage array. At the end of the phase the loaded bits are cleared and the block returns to idle.

The controller has four states:
- `ST_IDLE`: waiting for a first byte. It goes to `ST_LOAD` on any byte strobe.
- `ST_LOAD`: collecting bytes. It goes to `ST_COMMIT` once the gap limit is reached.
- `ST_COMMIT`: walking the buffer. It goes to `ST_HOLD` after the last byte index.
- `ST_HOLD`: waiting out the rest of the program time. It goes back to `ST_IDLE` when the program timer expires.

Top module: `eep_page_writer`

## Requirements
- R1: The byte address is taken in the first cycle in which ce_n and we_n are both low. The byte data is the din value of the last cycle in which both are low. The write completes in the cycle in which either strobe goes high.
- R2: A write happens only while ce_n=0, we_n=0 and oe_n=1. A strobe pulse with oe_n=0 loads no byte and does not start a program phase.
- R3: In `ST_IDLE`, a completed byte write opens a load period, latches the page number addr[ADDR_W-1:PAGE_W] and clears page_err.
- R4: During loading, a byte whose page number differs from the latched page is dropped and page_err goes to 1. page_err stays 1 until the next load period opens.
- R5: Bytes within a page may be loaded in any order. A byte offset written twice in one load period ends up holding the last value.
- R6: The load period closes after BYTE_WINDOW cycles with no accepted byte. busy then rises.
- R7: Only the offsets loaded in the period are written to the array. All other bytes of that page keep their previous contents.
- R8: busy stays high for exactly PROG_CYCLES cycles. All loaded marks are clear when it falls, so the next period writes only its own bytes.
- R9: Byte writes that complete while busy is high are ignored. They change neither the array nor the state.
- R10: dout is registered. One cycle after a cycle with ce_n=0, oe_n=0, we_n=1 and busy=0, dout shows the array byte at addr. After any other cycle it shows 0.
- R11: After reset, busy=0, page_err=0 and dout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page number in the upper bits, offset in the low PAGE_W bits |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data, 0 when not reading |
| busy | output | 1 | High from the close of a load period to the end of programming |
| page_err | output | 1 | Sticky flag for a byte sent to the wrong page |

## Verification
The bench builds the block with ADDR_W=10, PAGE_W=7, BYTE_WINDOW=16 and PROG_CYCLES=200. A 16-cycle gap limit is long enough for back-to-back strobe writes to stay in one load period. It is short enough that a whole 128-byte page fill and several load periods fit in a short run. A 200-cycle program phase lets the bench count every busy cycle exactly and still have time to attempt writes and reads while busy is high. The small array makes it practical to read back whole pages after a partial load.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } eep_state_t;
endpackage

// File: rtl/eep_strobe_sync.sv
module eep_strobe_sync #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              byte_stb,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data
);
    logic wr_act;
    logic wr_act_q;

    assign wr_act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            byte_addr <= '0;
            byte_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act && !wr_act_q) byte_addr <= addr;
            if (wr_act) byte_data <= din;
        end
    end

    assign byte_stb = wr_act_q && !wr_act;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0]     data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wr_idx] <= 1'b1;
        end
    end

    assign rd_data    = data_q[rd_idx];
    assign rd_loaded  = mask_q[rd_idx];
    assign any_loaded = |mask_q;
endmodule

// File: rtl/eep_nv_array.sv
module eep_nv_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int BYTE_WINDOW = 7500,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic              page_err
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TAG_W      = ADDR_W - PAGE_W;
    localparam int GAP_W      = $clog2(BYTE_WINDOW + 1);
    localparam int PROG_W     = $clog2(PROG_CYCLES + 1);

    eep_state_t        state_q, state_d;
    logic [GAP_W-1:0]  gap_q;
    logic [PROG_W-1:0] prog_q;
    logic [TAG_W-1:0]  tag_q;
    logic              err_q;

    logic              byte_stb;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] byte_data;
    logic [TAG_W-1:0]  stb_tag;
    logic              accept, mismatch, buf_clr;
    logic [PAGE_W-1:0] walk_idx;
    logic [DATA_W-1:0] buf_rdata, arr_rdata;
    logic              buf_loaded, any_loaded, arr_we;

    eep_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stb (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .byte_stb(byte_stb),
        .byte_addr(byte_addr), .byte_data(byte_data)
    );

    assign stb_tag  = byte_addr[ADDR_W-1:PAGE_W];
    assign walk_idx = prog_q[PAGE_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        busy     = 1'b0;
        accept   = 1'b0;
        mismatch = 1'b0;
        arr_we   = 1'b0;
        buf_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = byte_stb;
                if (byte_stb) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                accept   = byte_stb && (stb_tag == tag_q);
                mismatch = byte_stb && (stb_tag != tag_q);
                if (!accept && gap_q == GAP_W'(BYTE_WINDOW - 1)) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                arr_we = buf_loaded;
                if (prog_q == PROG_W'(PAGE_BYTES - 1)) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                busy = 1'b1;
                if (prog_q == PROG_W'(PROG_CYCLES - 1)) begin
                    state_d = ST_IDLE;
                    buf_clr = 1'b1;
                end
            end
        endcase
    end

    // counters, page tag and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            prog_q <= '0;
            tag_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept)                 gap_q <= '0;
            else if (state_q == ST_LOAD) gap_q <= gap_q + 1'b1;

            if (busy) prog_q <= prog_q + 1'b1;
            else      prog_q <= '0;

            if (state_q == ST_IDLE && byte_stb) begin
                tag_q <= stb_tag;
                err_q <= 1'b0;
            end else if (mismatch) begin
                err_q <= 1'b1;
            end
        end
    end

    eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_idx(byte_addr[PAGE_W-1:0]), .wr_data(byte_data),
        .clr(buf_clr), .rd_idx(walk_idx), .rd_data(buf_rdata),
        .rd_loaded(buf_loaded), .any_loaded(any_loaded)
    );

    eep_nv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(arr_we), .waddr({tag_q, walk_idx}), .wdata(buf_rdata),
        .raddr(addr), .rdata(arr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else if (!ce_n && !oe_n && we_n && !busy) dout <= arr_rdata;
        else dout <= '0;
    end

    assign page_err = err_q;
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
    import eep_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int GAP_W       = 4,
    parameter int BYTE_WINDOW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              page_err,
    input logic [DATA_W-1:0] dout,
    input eep_state_t        state,
    input logic [GAP_W-1:0]  gap,
    input logic              any_loaded,
    input logic              buf_we
);
    a_r10_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> dout == '0);

    a_r8_marks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_loaded);

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(page_err) |-> $past(state) == ST_IDLE);

    a_r6_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state) == ST_LOAD);

    a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD |-> gap < GAP_W'(BYTE_WINDOW));

    a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);
endmodule

bind eep_page_writer eep_page_writer_chk #(
    .DATA_W(DATA_W), .GAP_W(GAP_W), .BYTE_WINDOW(BYTE_WINDOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err), .dout(dout),
    .state(state_q), .gap(gap_q), .any_loaded(any_loaded), .buf_we(accept)
);

// File: tb/test_eep_page_writer.sv
module test_eep_page_writer;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int PW = 7;
    localparam int WIN = 16;
    localparam int PROG = 200;
    localparam int NVEC = 8;
    // {offset[7:0], data[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0A_C1, 16'h03_C2, 16'h7F_C3, 16'h00_C4,
        16'h0A_D5, 16'h40_C6, 16'h03_D7, 16'h01_C8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic busy, page_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model [1 << AW];

    always #10 clk = ~clk;

    eep_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW),
                      .BYTE_WINDOW(WIN), .PROG_CYCLES(PROG)) i_eep_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1; din = ~d;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); d = dout; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && !busy; k++) @(negedge clk);
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    task automatic check_page(input string req, input int pg);
        logic [DW-1:0] v;
        for (int i = 0; i < (1 << PW); i++) begin
            rd(AW'(pg * (1 << PW) + i), v);
            chk(req, v, model[pg * (1 << PW) + i]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 page_err", page_err, 0);
        chk("R11 dout", dout, 0);

        // R3 R7 fill page 0 completely
        for (int i = 0; i < (1 << PW); i++) begin
            wr(AW'(i), DW'(i * 7 + 3));
            model[i] = DW'(i * 7 + 3);
        end
        wait_idle();
        check_page("R3 full page", 0);

        // R5 R7 table walk: out of order, repeats, partial page
        for (int n = 0; n < NVEC; n++) begin
            wr(AW'(VEC[n][15:8]), VEC[n][7:0]);
            model[VEC[n][15:8]] = VEC[n][7:0];
        end
        wait_idle();
        check_page("R5 R7 partial page", 0);

        // R6 R8 window close and busy length
        wr(AW'(128 + 5), 8'h5E);
        model[128 + 5] = 8'h5E;
        cnt = 0;
        while (!busy && cnt < 100) begin @(negedge clk); cnt++; end
        chk("R6 window", (cnt >= WIN - 2 && cnt <= WIN + 2), 1);
        cnt = 0;
        while (busy && cnt < 1000) begin @(negedge clk); cnt++; end
        chk("R8 busy length", cnt, PROG);
        rd(AW'(128 + 5), v);
        chk("R8 committed", v, 8'h5E);

        // R4 page mismatch, R3 clear on next load
        wr(AW'(128 + 7), 8'h11); model[128 + 7] = 8'h11;
        wr(AW'(2), 8'h99);
        chk("R4 err set", page_err, 1);
        wr(AW'(128 + 8), 8'h22); model[128 + 8] = 8'h22;
        wait_idle();
        chk("R4 err sticky", page_err, 1);
        rd(AW'(2), v);
        chk("R4 dropped byte", v, model[2]);
        rd(AW'(128 + 7), v); chk("R4 good byte", v, 8'h11);
        rd(AW'(128 + 8), v); chk("R4 good byte", v, 8'h22);

        wr(AW'(128 + 9), 8'h33); model[128 + 9] = 8'h33;
        chk("R3 err cleared", page_err, 0);
        for (int k = 0; k < 100 && !busy; k++) @(negedge clk);
        // R10 read during busy, R9 write during busy
        rd(AW'(3), v);
        chk("R10 read busy", v, 0);
        wr(AW'(2), 8'hEE);
        wait_idle();
        repeat (WIN + 5) @(negedge clk);
        chk("R9 no new load", busy, 0);
        rd(AW'(2), v); chk("R9 array kept", v, model[2]);
        rd(AW'(128 + 9), v); chk("R8 next period", v, 8'h33);
        rd(AW'(128 + 5), v); chk("R8 old byte kept", v, 8'h5E);

        // R10 no output without oe
        @(negedge clk); addr = AW'(3); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R10 oe high", dout, 0); ce_n = 1'b1;

        // R2 inhibit by oe low
        @(negedge clk); oe_n = 1'b0; addr = AW'(4); din = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (WIN + 5) @(negedge clk);
        chk("R2 inhibit busy", busy, 0);
        rd(AW'(4), v); chk("R2 inhibit data", v, model[4]);

        // R1 address on later low edge, data before first high edge
        @(negedge clk); addr = AW'(40); din = 8'h77; ce_n = 1'b0;
        @(negedge clk); addr = AW'(41); din = 8'hA1; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1; din = 8'h00;
        @(negedge clk); ce_n = 1'b1;
        model[41] = 8'hA1;
        wait_idle();
        rd(AW'(41), v); chk("R1 capture data", v, 8'hA1);
        rd(AW'(40), v); chk("R1 other addr", v, model[40]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule